// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit gathers the one-cycle event pulses that an I2C transfer engine raises (arbitration lost, NACK received, access ready, receive data ready, transmit ready, stop detected, addressed as slave) into sticky status flags. Each flag is gated by a mask bit. The unit drives a single interrupt request line whenever any enabled flag is pending.

Software reaches the unit through a 16-bit register port. It holds a mask register, a status register and a vector register. The status register also shows two live levels from the engine: bus busy and receive shift register full. The vector register returns a small code that names the highest-priority enabled pending event, and 0 when nothing enabled is pending. Reading the vector consumes the event it reports, so a service routine can read the vector in a loop until it returns 0. Two of the flags (access ready and stop detected) can also be cleared by writing a 1 to their status bit.

Top module: `i2c_irq_vector_unit`

## Requirements
- R1: After a synchronous active-high reset, all flags and all mask bits are 0, `irq` is 0 and `reg_rdata` is 0.
- R2: An event pulse on `evt_pulse[i]` sets status flag i, and the flag stays set until it is cleared. The bit positions are: arbitration lost 0, NACK 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R3: A read at offset 0x08 returns the flags in bits 6:0, `bus_busy` in bit 12 and `rx_shift_full` in bit 11. All other bits read 0.
- R4: The mask register at offset 0x04 stores bits 6:0 of a write. It reads back those bits, and bits 15:7 read 0.
- R5: A write to offset 0x08 clears flag 2 and flag 5 where the written data bit is 1. Every other status bit, and every 0 data bit, has no effect.
- R6: A read at offset 0x28 returns code i+1 for the lowest-index flag i that is both set and enabled, and returns 0 when no enabled flag is set. Flags whose mask bit is 0 are never reported.
- R7: A vector read that returns a nonzero code clears exactly the reported flag. A vector read that returns 0 changes no flag.
- R8: `irq` is 1 exactly when at least one flag is set together with its mask bit. It follows the flag and mask registers in the same clock cycle as they change.
- R9: If an event pulse arrives in the same cycle as a clear of its flag (by a status write or a vector read), the flag stays set.
- R10: `reg_rdata` shows the read value in the cycle after `reg_rd`. It is 0 after any cycle without a read, and 0 for any offset other than 0x04, 0x08 or 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 7 | One-cycle event pulses from the transfer engine, indexed by status bit |
| bus_busy | input | 1 | Bus-busy level, shown in status bit 12 |
| rx_shift_full | input | 1 | Receive shift register full level, shown in status bit 11 |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that the engine's event inputs are clean single-cycle pulses sampled at the clock edge. They also assume that the register port never issues a read and a write in the same cycle. The stimulus holds to both: each cycle drives either one access or none, and events are drawn per bit with no other timing constraint. The stimulus deliberately places events on top of status-write clears and vector-read clears, because those collisions are where the precedence rule matters. It also drives the two status levels independently of the flags.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_EVT  = 7;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int BUSY_BIT = 12;
  localparam int RXF_BIT  = 11;
  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_VEC  = 6'h28;
  localparam logic [NUM_EVT-1:0] W1C_BITS = 7'b0100100;
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] flags_o,
  output logic [NUM_EVT-1:0] flags_d_o
);
  logic [NUM_EVT-1:0] flags_q;

  // a new event outranks a clear in the same cycle
  assign flags_d_o = evt_i | (flags_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d_o;
  end

  assign flags_o = flags_q;

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & clr_i)) |=> ((flags_q & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

  p_clear_takes_r5: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~evt_i)) |=> ((flags_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int NUM_EVT = 7,
  localparam int CODE_W = $clog2(NUM_EVT + 1)
) (
  input  logic [NUM_EVT-1:0] pend_i,
  output logic [NUM_EVT-1:0] sel_o,
  output logic [CODE_W-1:0]  code_o
);
  logic [NUM_EVT:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chain
    assign seen[i+1] = seen[i] | pend_i[i];
    assign sel_o[i]  = pend_i[i] & ~seen[i];
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_o[i]) code_o = code_o | CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/irqv_regport.sv
module irqv_regport
  import irqv_pkg::*;
#(
  parameter int NUM_EVT = irqv_pkg::NUM_EVT,
  parameter int DATA_W  = irqv_pkg::DATA_W,
  parameter int ADDR_W  = irqv_pkg::ADDR_W,
  localparam int CODE_W = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EVT-1:0] flags_i,
  input  logic [NUM_EVT-1:0] sel_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               busy_i,
  input  logic               rxf_i,
  output logic [NUM_EVT-1:0] mask_o,
  output logic [NUM_EVT-1:0] mask_d_o,
  output logic [NUM_EVT-1:0] clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_EVT-1:0] mask_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  stat_word;
  logic [DATA_W-1:0]  rd_mux;
  logic [NUM_EVT-1:0] w1c_clr;
  logic [NUM_EVT-1:0] vec_clr;
  logic               hit_mask, hit_stat, hit_vec;
  logic               unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:NUM_EVT];

  assign hit_mask = (addr_i == OFS_MASK);
  assign hit_stat = (addr_i == OFS_STAT);
  assign hit_vec  = (addr_i == OFS_VEC);

  assign w1c_clr  = (wr_i && hit_stat) ? (wdata_i[NUM_EVT-1:0] & W1C_BITS) : '0;
  assign vec_clr  = (rd_i && hit_vec) ? sel_i : '0;
  assign clr_o    = w1c_clr | vec_clr;
  assign mask_d_o = (wr_i && hit_mask) ? wdata_i[NUM_EVT-1:0] : mask_q;

  always_comb begin
    stat_word = '0;
    stat_word[NUM_EVT-1:0] = flags_i;
    stat_word[BUSY_BIT]    = busy_i;
    stat_word[RXF_BIT]     = rxf_i;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_mask)     rd_mux[NUM_EVT-1:0] = mask_q;
    else if (hit_stat) rd_mux = stat_word;
    else if (hit_vec)  rd_mux[CODE_W-1:0] = code_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d_o;
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  p_one_vec_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_clr));

  p_vec_clear_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    ((vec_clr & ~(flags_i & mask_q)) == '0));

  p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_i && hit_vec) |=> (rdata_q[DATA_W-1:CODE_W] == '0));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (rdata_q == '0));
endmodule

// File: rtl/i2c_irq_vector_unit.sv
module i2c_irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int NUM_EVT = irqv_pkg::NUM_EVT,
  parameter int DATA_W  = irqv_pkg::DATA_W,
  parameter int ADDR_W  = irqv_pkg::ADDR_W,
  localparam int CODE_W = $clog2(NUM_EVT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               bus_busy,
  input  logic               rx_shift_full,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  logic [NUM_EVT-1:0] flags, flags_d, mask, mask_d, clr, sel;
  logic [CODE_W-1:0]  code;
  logic               irq_q;

  irqv_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk(clk), .rst(rst), .evt_i(evt_pulse), .clr_i(clr),
    .flags_o(flags), .flags_d_o(flags_d)
  );

  irqv_prio_enc #(.NUM_EVT(NUM_EVT)) u_enc (
    .pend_i(flags & mask), .sel_o(sel), .code_o(code)
  );

  irqv_regport #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .rd_i(reg_rd), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .flags_i(flags), .sel_i(sel), .code_i(code),
    .busy_i(bus_busy), .rxf_i(rx_shift_full), .mask_o(mask),
    .mask_d_o(mask_d), .clr_o(clr), .rdata_o(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_d & mask_d);
  end

  assign irq = irq_q;

  p_irq_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flags & mask));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_q && reg_rdata == '0));
endmodule

// File: tb/sim_i2c_irq_vector_unit.sv
module sim_i2c_irq_vector_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  evt = '0;
  logic        busy = 1'b0, rxf = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  logic [6:0]  m_flags, m_mask;
  logic        m_irq;
  logic [15:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_vector_unit u0 (
    .clk(clk), .rst(rst), .evt_pulse(evt), .bus_busy(busy),
    .rx_shift_full(rxf), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  always @(posedge clk) begin
    logic [6:0] pend, nf, nm;
    int code;
    if (rst) begin
      m_flags = '0; m_mask = '0; m_irq = 0; m_rdata = '0;
    end else begin
      pend = m_flags & m_mask;
      code = 0;
      for (int i = 6; i >= 0; i--) if (pend[i]) code = i + 1;
      m_rdata = '0;
      if (rd) begin
        if (addr == 6'h04) m_rdata = {9'd0, m_mask};
        else if (addr == 6'h08) m_rdata = {3'd0, busy, rxf, 4'd0, m_flags};
        else if (addr == 6'h28) m_rdata = 16'(code);
      end
      nf = m_flags;
      nm = m_mask;
      if (wr && addr == 6'h08) nf = nf & ~(wdata[6:0] & 7'b0100100);
      if (rd && addr == 6'h28 && code != 0) nf[code-1] = 1'b0;
      nf = nf | evt;
      if (wr && addr == 6'h04) nm = wdata[6:0];
      m_flags = nf; m_mask = nm;
      m_irq = |(nf & nm);
    end
  end

  task automatic compare();
    checks++;
    if (irq !== m_irq) begin
      failures++;
      $display("FAIL R8 irq actual=%0b expected=%0b", irq, m_irq);
    end
    checks++;
    if (rdata !== m_rdata) begin
      failures++;
      $display("FAIL %s reg_rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
    end
  endtask

  task automatic step(input logic [6:0] e, input logic w, input logic r,
                      input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    compare();
    evt = e; wr = w; rd = r; addr = a; wdata = d;
  endtask

  task automatic idle();
    step('0, 0, 0, '0, '0);
  endtask

  task automatic rd_reg(input logic [5:0] a);
    step('0, 0, 1, a, '0);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
    step('0, 1, 0, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    idle();
    rd_reg(6'h08); rd_reg(6'h04); rd_reg(6'h28); idle();
    // R2: each event sets its bit, mask still 0 so irq stays low
    cur_req = "R2";
    for (int i = 0; i < 7; i++) begin
      step(7'(1 << i), 0, 0, '0, '0);
      rd_reg(6'h08); idle();
    end
    // R5: writing all ones clears only bits 2 and 5
    cur_req = "R5";
    wr_reg(6'h08, 16'hFFFF); rd_reg(6'h08);
    wr_reg(6'h08, 16'h0000); rd_reg(6'h08); idle();
    // R4: mask write and read back
    cur_req = "R4";
    wr_reg(6'h04, 16'hFFFF); rd_reg(6'h04); idle();
    // R6 / R7: vector loop drains in priority order down to 0
    cur_req = "R6";
    step(7'h7F, 0, 0, '0, '0);
    cur_req = "R7";
    for (int k = 0; k < 9; k++) rd_reg(6'h28);
    idle();
    // R6: masked event never reported
    cur_req = "R6";
    wr_reg(6'h04, 16'h0004);
    step(7'h05, 0, 0, '0, '0);
    rd_reg(6'h28); rd_reg(6'h28); rd_reg(6'h28); rd_reg(6'h08); idle();
    // R9: event coincides with vector-read clear and with status-write clear
    cur_req = "R9";
    wr_reg(6'h04, 16'h007F);
    step(7'h01, 0, 0, '0, '0);
    step(7'h01, 0, 1, 6'h28, '0);
    rd_reg(6'h08);
    step(7'h20, 0, 0, '0, '0);
    step(7'h20, 1, 0, 6'h08, 16'h0020);
    rd_reg(6'h08); idle();
    // R3: status levels
    cur_req = "R3";
    busy = 1; rxf = 0; rd_reg(6'h08);
    busy = 0; rxf = 1; rd_reg(6'h08);
    busy = 1; rxf = 1; rd_reg(6'h08); idle();
    // R10: unknown offsets and write-only cycles read 0
    cur_req = "R10";
    rd_reg(6'h00); rd_reg(6'h2C); wr_reg(6'h3F, 16'hFFFF); idle();
    // R8 and everything else: random mixed traffic compared every clock
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] e;
      int op;
      logic [5:0] a;
      e = 7'($urandom) & 7'($urandom) & 7'($urandom);
      op = int'($urandom % 4);
      case ($urandom % 4)
        0: a = 6'h04;
        1: a = 6'h08;
        2: a = 6'h28;
        default: a = 6'h10;
      endcase
      busy = 1'($urandom); rxf = 1'($urandom);
      cur_req = (a == 6'h28) ? "R7" : "R10";
      if (op == 0)      step(e, 1, 0, a, 16'($urandom));
      else if (op == 1) step(e, 0, 0, '0, '0);
      else              step(e, 0, 1, a, '0);
    end
    idle();
    // R1: reset in the middle of activity
    cur_req = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    idle(); rd_reg(6'h04); rd_reg(6'h08); idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule